// File: doc/BRIEF.md
# Multi-Page-Size Associative TLB Lookup

This block is a fully associative translation lookaside buffer for a 64-bit virtual and 41-bit physical address space. Every entry carries a virtual page tag with a 13-bit context and a translation record: valid, global, a 2-bit page size, privileged, writable, no-fault-only and side-effect flags, and a used bit. Each entry compares itself against the lookup address under a mask set by its own page size of 8 KB, 64 KB, 512 KB or 4 MB. All entries are compared at once.

A lookup names an access kind (load, store, non-faulting load), a context space (primary, secondary, nucleus) and whether it comes from user mode. One cycle later the block returns a registered result: a physical address with permissions, a miss, a data fault or a write-protection fault. Faults and misses update a fault status word, a fault address and a tag-access register. Entries are loaded through a single write port. Table walking is left to the surrounding logic.

Top module: `assoc_tlb`

## Requirements
- R1: The 2-bit size field sets how many low tag bits an entry ignores. Values 0, 1, 2 and 3 compare virtual bits 63:13, 63:16, 63:19 and 63:22, which gives 8 KB, 64 KB, 512 KB and 4 MB pages.
- R2: An entry matches only when three conditions hold: its valid bit is set, its masked tag equals the masked virtual address, and either its global bit is set or its context equals the selected context.
- R3: The 13-bit lookup context depends on `req_space`. A value of 0 uses `pri_ctx`, a value of 1 uses `sec_ctx`, and 2 or 3 use context zero.
- R4: On a translated hit, physical bits 40:13 come from the entry's frame bits above the size mask and from the virtual address below it. Physical bits 12:0 are zero.
- R5: When several entries match, the lowest-numbered entry supplies the result.
- R6: `req_kind` encodes 0 as load, 1 as store, 2 as non-faulting load and 3 as load. A matching entry raises `rsp_fault` under any of three conditions: a user access to a privileged entry, a non-faulting load to a side-effect entry, or any other kind of access to a no-fault-only entry. Every condition that holds is recorded.
- R7: A store that matches an entry without write permission and raises no data fault gives `rsp_prot`. Each valid response asserts exactly one of hit, miss, fault and prot.
- R8: A fault or protection fault loads `stat_fsr`, `stat_far` and `stat_tag`. The `stat_fsr` bits are: 0 valid, 1 overflow, 2 store, 3 non-faulting, 4 privileged mode (not user), 5 privilege fault, 6 side-effect fault, 7 no-fault-only fault, and 9:8 space (0 primary, 1 secondary, 2 nucleus). A fault writes the whole word, with valid set and overflow set when valid was already set. `stat_far` takes the virtual address. `stat_tag` takes VA[63:13] with the context in bits 12:0.
- R9: On a miss, `rsp_miss` is raised and only `stat_tag` changes. `stat_fsr` and `stat_far` keep their values.
- R10: A clean hit sets the entry's bit in `used_bits` and returns read permission, plus write permission when the entry is writable. Writing an entry clears its used bit.
- R11: While `mmu_en` is low, every lookup hits with read and write permission, and the physical address is VA[40:0]. No status register changes.
- R12: A response appears in the cycle after its request, with `rsp_valid`. An entry write is visible to a lookup in the next cycle. A pulse on `stat_clr` zeroes `stat_fsr` before any fault in the same cycle is recorded. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmu_en | input | 1 | Translation enable |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| stat_clr | input | 1 | Clear fault status word |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry number to write |
| wr_vpn | input | 51 | Virtual page tag (VA[63:13]) |
| wr_ctx | input | 13 | Entry context |
| wr_ppn | input | 28 | Physical frame (PA[40:13]) |
| wr_valid | input | 1 | Entry valid |
| wr_global | input | 1 | Entry ignores context |
| wr_size | input | 2 | Page size code |
| wr_priv | input | 1 | Privileged-only entry |
| wr_writable | input | 1 | Writes permitted |
| wr_nfo | input | 1 | Only non-faulting loads permitted |
| wr_side | input | 1 | Page has side effects |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind |
| req_space | input | 2 | Context space |
| req_user | input | 1 | Access from user mode |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation granted |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Data access fault |
| rsp_prot | output | 1 | Write-protection fault |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_pa | output | 41 | Physical address |
| stat_fsr | output | 10 | Fault status word |
| stat_far | output | 64 | Fault address |
| stat_tag | output | 64 | Tag-access register |
| used_bits | output | 64 | Per-entry used flags |

## Verification
Every lookup result, and any change it makes to the status, fault-address, tag-access and used registers, is due at the first rising edge after the request cycle. The bench drives a request on a falling edge and drops it on the next falling edge. It compares every output at that same falling edge, midway between the edge that registered the result and the edge that clears it. Entry writes and status clears use the same half-cycle rhythm, so each lookup sees the state left by the operation before it, as R12 requires.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

  localparam int PG_SHIFT = 13;

  typedef enum logic [1:0] {
    ACC_LOAD   = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_NFLOAD = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    SPC_PRIMARY   = 2'd0,
    SPC_SECONDARY = 2'd1,
    SPC_NUCLEUS   = 2'd2
  } ctx_space_e;

  // translation attributes kept per entry (valid and used held apart)
  typedef struct packed {
    logic       global;
    logic [1:0] size;
    logic       priv;
    logic       writable;
    logic       nfo;
    logic       side;
  } tte_attr_t;

  // fault status word, bit 0 is valid
  typedef struct packed {
    logic [1:0] space;
    logic       ft_nfo;
    logic       ft_side;
    logic       ft_priv;
    logic       priv_mode;
    logic       nf;
    logic       store;
    logic       ovf;
    logic       valid;
  } fsr_t;

  localparam int FSR_W = $bits(fsr_t);

  // number of tag bits above PG_SHIFT ignored by a page-size code (3 per step)
  function automatic logic [3:0] sz_lsb(input logic [1:0] sz);
    return {2'b00, sz} + {1'b0, sz, 1'b0};
  endfunction

endpackage

// File: rtl/tlb_entry_match.sv
`timescale 1ns/1ps
module tlb_entry_match
  import tlb_pkg::*;
#(
  parameter int VPN_W = 51,
  parameter int CTX_W = 13
) (
  input  logic             ent_valid,
  input  tte_attr_t        ent_attr,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic [CTX_W-1:0] ent_ctx,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [CTX_W-1:0] look_ctx,
  output logic             hit
);

  logic [VPN_W-1:0] keep;
  logic             tag_eq;
  logic             ctx_ok;

  always_comb begin
    keep   = {VPN_W{1'b1}} << sz_lsb(ent_attr.size);
    tag_eq = ((ent_vpn ^ look_vpn) & keep) == '0;
    ctx_ok = ent_attr.global | (ent_ctx == look_ctx);
    hit    = ent_valid & tag_eq & ctx_ok;
  end

  // ent_attr fields other than global/size are used by the top, not here
  logic unused_attr;
  assign unused_attr = ^{ent_attr.priv, ent_attr.writable, ent_attr.nfo, ent_attr.side};

endmodule

// File: rtl/tlb_prio_sel.sv
`timescale 1ns/1ps
module tlb_prio_sel #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);

  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx      = IDX_W'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/tlb_fault_regs.sv
`timescale 1ns/1ps
module tlb_fault_regs
  import tlb_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int CTX_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stat_clr,
  input  logic             rec_fault,
  input  logic             rec_miss,
  input  logic [1:0]       in_space,
  input  logic             in_ft_priv,
  input  logic             in_ft_side,
  input  logic             in_ft_nfo,
  input  logic             in_priv_mode,
  input  logic             in_nf,
  input  logic             in_store,
  input  logic [VA_W-1:0]  in_va,
  input  logic [CTX_W-1:0] in_ctx,
  output fsr_t             fsr_q,
  output logic [VA_W-1:0]  far_q,
  output logic [VA_W-1:0]  tag_q
);

  logic [VA_W-1:0] tag_next;
  fsr_t            fsr_new;

  always_comb begin
    tag_next          = {in_va[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}} | VA_W'(in_ctx);
    fsr_new.space     = in_space;
    fsr_new.ft_nfo    = in_ft_nfo;
    fsr_new.ft_side   = in_ft_side;
    fsr_new.ft_priv   = in_ft_priv;
    fsr_new.priv_mode = in_priv_mode;
    fsr_new.nf        = in_nf;
    fsr_new.store     = in_store;
    fsr_new.ovf       = fsr_q.valid & ~stat_clr;
    fsr_new.valid     = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q <= '0;
      far_q <= '0;
      tag_q <= '0;
    end else begin
      if (stat_clr) fsr_q <= '0;
      if (rec_fault) begin
        fsr_q <= fsr_new;
        far_q <= in_va;
      end
      if (rec_fault | rec_miss) tag_q <= tag_next;
    end
  end

  AST_MISS_HOLDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (rec_miss && !stat_clr) |=> ($stable(fsr_q) && $stable(far_q))); // R9

  AST_FAULT_MARKS_VALID: assert property (@(posedge clk) disable iff (rst)
    rec_fault |=> fsr_q.valid); // R8

  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rec_fault && fsr_q.valid && !stat_clr) |=> fsr_q.ovf); // R8

endmodule

// File: rtl/assoc_tlb.sv
`timescale 1ns/1ps
module assoc_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int VA_W        = 64,
  parameter int PA_W        = 41,
  parameter int CTX_W       = 13,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int VPN_W      = VA_W - PG_SHIFT,
  localparam int PPN_W      = PA_W - PG_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   mmu_en,
  input  logic [CTX_W-1:0]       pri_ctx,
  input  logic [CTX_W-1:0]       sec_ctx,
  input  logic                   stat_clr,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [VPN_W-1:0]       wr_vpn,
  input  logic [CTX_W-1:0]       wr_ctx,
  input  logic [PPN_W-1:0]       wr_ppn,
  input  logic                   wr_valid,
  input  logic                   wr_global,
  input  logic [1:0]             wr_size,
  input  logic                   wr_priv,
  input  logic                   wr_writable,
  input  logic                   wr_nfo,
  input  logic                   wr_side,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_va,
  input  logic [1:0]             req_kind,
  input  logic [1:0]             req_space,
  input  logic                   req_user,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_miss,
  output logic                   rsp_fault,
  output logic                   rsp_prot,
  output logic                   rsp_rd,
  output logic                   rsp_wr,
  output logic [PA_W-1:0]        rsp_pa,
  output logic [FSR_W-1:0]       stat_fsr,
  output logic [VA_W-1:0]        stat_far,
  output logic [VA_W-1:0]        stat_tag,
  output logic [NUM_ENTRIES-1:0] used_bits
);

  // ---------------- entry storage ----------------
  logic [VPN_W-1:0]       ent_vpn  [NUM_ENTRIES];
  logic [CTX_W-1:0]       ent_ctx  [NUM_ENTRIES];
  logic [PPN_W-1:0]       ent_ppn  [NUM_ENTRIES];
  tte_attr_t              ent_attr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] valid_q;
  logic [NUM_ENTRIES-1:0] used_q;

  tte_attr_t wr_attr;
  always_comb begin
    wr_attr.global   = wr_global;
    wr_attr.size     = wr_size;
    wr_attr.priv     = wr_priv;
    wr_attr.writable = wr_writable;
    wr_attr.nfo      = wr_nfo;
    wr_attr.side     = wr_side;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_vpn[wr_idx]  <= wr_vpn;
      ent_ctx[wr_idx]  <= wr_ctx;
      ent_ppn[wr_idx]  <= wr_ppn;
      ent_attr[wr_idx] <= wr_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= wr_valid;
  end

  // ---------------- context selection ----------------
  logic [CTX_W-1:0] look_ctx;
  logic [1:0]       space_rec;
  logic [VPN_W-1:0] look_vpn;

  always_comb begin
    look_vpn = req_va[VA_W-1:PG_SHIFT];
    case (req_space)
      SPC_PRIMARY:   begin look_ctx = pri_ctx; space_rec = SPC_PRIMARY;   end
      SPC_SECONDARY: begin look_ctx = sec_ctx; space_rec = SPC_SECONDARY; end
      default:       begin look_ctx = '0;      space_rec = SPC_NUCLEUS;   end
    endcase
  end

  // ---------------- parallel compare ----------------
  logic [NUM_ENTRIES-1:0] match;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    tlb_entry_match #(
      .VPN_W (VPN_W),
      .CTX_W (CTX_W)
    ) u_match (
      .ent_valid (valid_q[g]),
      .ent_attr  (ent_attr[g]),
      .ent_vpn   (ent_vpn[g]),
      .ent_ctx   (ent_ctx[g]),
      .look_vpn  (look_vpn),
      .look_ctx  (look_ctx),
      .hit       (match[g])
    );
  end

  logic                   any_hit;
  logic [IDX_W-1:0]       hit_idx;
  logic [NUM_ENTRIES-1:0] grant;

  tlb_prio_sel #(
    .N     (NUM_ENTRIES),
    .IDX_W (IDX_W)
  ) u_prio (
    .req   (match),
    .any   (any_hit),
    .idx   (hit_idx),
    .grant (grant)
  );

  // ---------------- access checks and address build ----------------
  logic             sel_priv, sel_wr, sel_nfo, sel_side;
  logic [1:0]       sel_size;
  logic [PPN_W-1:0] sel_ppn, ppn_keep, xl_ppn;
  logic             is_store, is_nf;
  logic             ft_priv, ft_side, ft_nfo, dfault, prot;
  logic             xl_ok;

  always_comb begin
    sel_priv = ent_attr[hit_idx].priv;
    sel_wr   = ent_attr[hit_idx].writable;
    sel_nfo  = ent_attr[hit_idx].nfo;
    sel_side = ent_attr[hit_idx].side;
    sel_size = ent_attr[hit_idx].size;
    sel_ppn  = ent_ppn[hit_idx];
    ppn_keep = {PPN_W{1'b1}} << sz_lsb(sel_size);
    xl_ppn   = (sel_ppn & ppn_keep) | (req_va[PA_W-1:PG_SHIFT] & ~ppn_keep);
    is_store = (req_kind == ACC_STORE);
    is_nf    = (req_kind == ACC_NFLOAD);
    ft_priv  = sel_priv & req_user;
    ft_side  = is_nf & sel_side;
    ft_nfo   = ~is_nf & sel_nfo;
    dfault   = ft_priv | ft_side | ft_nfo;
    prot     = ~dfault & is_store & ~sel_wr;
    xl_ok    = req_valid & mmu_en & any_hit & ~dfault & ~prot;
  end

  // ---------------- used flags ----------------
  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else begin
      if (xl_ok) used_q[hit_idx] <= 1'b1;
      if (wr_en) used_q[wr_idx] <= 1'b0;
    end
  end
  assign used_bits = used_q;

  // ---------------- registered response ----------------
  logic xlated_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_pa    <= '0;
      xlated_q  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_pa    <= '0;
      xlated_q  <= 1'b0;
      if (req_valid) begin
        if (!mmu_en) begin
          rsp_hit <= 1'b1;
          rsp_rd  <= 1'b1;
          rsp_wr  <= 1'b1;
          rsp_pa  <= req_va[PA_W-1:0];
        end else if (!any_hit) begin
          rsp_miss <= 1'b1;
        end else if (dfault) begin
          rsp_fault <= 1'b1;
        end else if (prot) begin
          rsp_prot <= 1'b1;
        end else begin
          rsp_hit  <= 1'b1;
          rsp_rd   <= 1'b1;
          rsp_wr   <= sel_wr;
          rsp_pa   <= {xl_ppn, {PG_SHIFT{1'b0}}};
          xlated_q <= 1'b1;
        end
      end
    end
  end

  // ---------------- fault recording ----------------
  fsr_t fsr_w;

  tlb_fault_regs #(
    .VA_W  (VA_W),
    .CTX_W (CTX_W)
  ) u_fregs (
    .clk          (clk),
    .rst          (rst),
    .stat_clr     (stat_clr),
    .rec_fault    (req_valid & mmu_en & any_hit & (dfault | prot)),
    .rec_miss     (req_valid & mmu_en & ~any_hit),
    .in_space     (space_rec),
    .in_ft_priv   (ft_priv),
    .in_ft_side   (ft_side),
    .in_ft_nfo    (ft_nfo),
    .in_priv_mode (~req_user),
    .in_nf        (is_nf),
    .in_store     (is_store),
    .in_va        (req_va),
    .in_ctx       (look_ctx),
    .fsr_q        (fsr_w),
    .far_q        (stat_far),
    .tag_q        (stat_tag)
  );

  assign stat_fsr = fsr_w;

  // ---------------- assertions ----------------
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R12

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault, rsp_prot}) == 1)); // R7

  AST_PA_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && xlated_q) |-> (rsp_pa[PG_SHIFT-1:0] == '0)); // R4

  AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mmu_en) |=> (rsp_hit && rsp_rd && rsp_wr && rsp_pa == $past(req_va[PA_W-1:0]))); // R11

  AST_USED_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (xl_ok && !wr_en) |=> ((used_q & $past(grant)) != '0)); // R10

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~match) == '0)); // R5

endmodule

// File: tb/assoc_tlb_test.sv
`timescale 1ns/1ps
module assoc_tlb_test;

  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mmu_en, stat_clr, wr_en, req_valid, req_user;
  logic [12:0]   pri_ctx, sec_ctx, wr_ctx;
  logic [2:0]    wr_idx;
  logic [50:0]   wr_vpn;
  logic [27:0]   wr_ppn;
  logic          wr_valid, wr_global, wr_priv, wr_writable, wr_nfo, wr_side;
  logic [1:0]    wr_size, req_kind, req_space;
  logic [63:0]   req_va;
  logic          rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_prot, rsp_rd, rsp_wr;
  logic [40:0]   rsp_pa;
  logic [9:0]    stat_fsr;
  logic [63:0]   stat_far, stat_tag;
  logic [N-1:0]  used_bits;

  always #2.5 clk = ~clk;

  assoc_tlb #(.NUM_ENTRIES(N)) uut (
    .clk(clk), .rst(rst), .mmu_en(mmu_en), .pri_ctx(pri_ctx), .sec_ctx(sec_ctx),
    .stat_clr(stat_clr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_ctx(wr_ctx), .wr_ppn(wr_ppn), .wr_valid(wr_valid), .wr_global(wr_global),
    .wr_size(wr_size), .wr_priv(wr_priv), .wr_writable(wr_writable),
    .wr_nfo(wr_nfo), .wr_side(wr_side), .req_valid(req_valid), .req_va(req_va),
    .req_kind(req_kind), .req_space(req_space), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_prot(rsp_prot), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .rsp_pa(rsp_pa), .stat_fsr(stat_fsr), .stat_far(stat_far),
    .stat_tag(stat_tag), .used_bits(used_bits)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // bench-side model state
  logic        m_valid [N];
  logic [50:0] m_vpn   [N];
  logic [12:0] m_ctx   [N];
  logic [27:0] m_ppn   [N];
  logic        m_glob  [N];
  logic [1:0]  m_size  [N];
  logic        m_priv  [N];
  logic        m_wr    [N];
  logic        m_nfo   [N];
  logic        m_side  [N];
  logic [N-1:0] m_used;
  logic [9:0]  m_fsr;
  logic [63:0] m_far, m_tag;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_ent(input int idx, input logic [50:0] vpn, input logic [12:0] ctx,
                        input logic [27:0] ppn, input logic v, input logic g,
                        input logic [1:0] sz, input logic p, input logic w,
                        input logic nfo, input logic side);
    wr_idx = idx[2:0]; wr_vpn = vpn; wr_ctx = ctx; wr_ppn = ppn; wr_valid = v;
    wr_global = g; wr_size = sz; wr_priv = p; wr_writable = w; wr_nfo = nfo;
    wr_side = side; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    m_valid[idx] = v; m_vpn[idx] = vpn; m_ctx[idx] = ctx; m_ppn[idx] = ppn;
    m_glob[idx] = g; m_size[idx] = sz; m_priv[idx] = p; m_wr[idx] = w;
    m_nfo[idx] = nfo; m_side[idx] = side; m_used[idx] = 1'b0;
  endtask

  task automatic clr_status();
    stat_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stat_clr = 1'b0;
    m_fsr = '0;
  endtask

  task automatic lookup(input logic [63:0] va, input logic [1:0] kind,
                        input logic [1:0] space, input logic user, input string req);
    logic [12:0] ctx;
    logic [1:0]  sp_rec;
    int          hit_i;
    int          sh;
    logic [27:0] keep;
    logic        fp, fs, fn;
    logic        e_hit, e_miss, e_fault, e_prot, e_rd, e_wr;
    logic [40:0] e_pa;
    ctx    = (space == 2'd0) ? pri_ctx : (space == 2'd1) ? sec_ctx : 13'd0;
    sp_rec = (space == 2'd3) ? 2'd2 : space;
    hit_i  = -1;
    for (int i = N - 1; i >= 0; i--) begin
      sh = 3 * int'(m_size[i]);
      if (m_valid[i] && (((va[63:13] ^ m_vpn[i]) >> sh) == 51'd0) &&
          (m_glob[i] || m_ctx[i] == ctx)) hit_i = i;
    end
    e_hit = 0; e_miss = 0; e_fault = 0; e_prot = 0; e_rd = 0; e_wr = 0; e_pa = '0;
    if (!mmu_en) begin
      e_hit = 1; e_rd = 1; e_wr = 1; e_pa = va[40:0];
    end else if (hit_i < 0) begin
      e_miss = 1;
      m_tag  = {va[63:13], ctx};
    end else begin
      fp = m_priv[hit_i] && user;
      fs = (kind == 2'd2) && m_side[hit_i];
      fn = (kind != 2'd2) && m_nfo[hit_i];
      if (fp || fs || fn) e_fault = 1;
      else if (kind == 2'd1 && !m_wr[hit_i]) e_prot = 1;
      if (e_fault || e_prot) begin
        m_fsr = {sp_rec, fn, fs, fp, ~user, kind == 2'd2, kind == 2'd1, m_fsr[0], 1'b1};
        m_far = va;
        m_tag = {va[63:13], ctx};
      end else begin
        sh     = 3 * int'(m_size[hit_i]);
        keep   = 28'hFFFFFFF << sh;
        e_hit  = 1; e_rd = 1; e_wr = m_wr[hit_i];
        e_pa   = {(m_ppn[hit_i] & keep) | (va[40:13] & ~keep), 13'd0};
        m_used[hit_i] = 1'b1;
      end
    end
    req_va = va; req_kind = kind; req_space = space; req_user = user; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(req, "outcome hit/miss/fault/prot", 64'({rsp_hit, rsp_miss, rsp_fault, rsp_prot}),
        64'({e_hit, e_miss, e_fault, e_prot}));
    chk(req, "rd/wr", 64'({rsp_rd, rsp_wr}), 64'({e_rd, e_wr}));
    chk(req, "pa", 64'(rsp_pa), 64'(e_pa));
    chk(req, "fsr", 64'(stat_fsr), 64'(m_fsr));
    chk(req, "far", stat_far, m_far);
    chk(req, "tag", stat_tag, m_tag);
    chk(req, "used R10", 64'(used_bits), 64'(m_used));
  endtask

  localparam logic [63:0] VA_A = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] VA_B = 64'h0000_7F00_1234_A000;
  localparam logic [63:0] VA_C = 64'h0123_0000_00C0_0000;
  localparam logic [63:0] VA_D = 64'h8000_0000_5555_0000;

  initial begin
    mmu_en = 0; stat_clr = 0; wr_en = 0; req_valid = 0; req_user = 0;
    pri_ctx = 13'h0A5; sec_ctx = 13'h1F3; wr_ctx = 0; wr_idx = 0; wr_vpn = 0;
    wr_ppn = 0; wr_valid = 0; wr_global = 0; wr_priv = 0; wr_writable = 0;
    wr_nfo = 0; wr_side = 0; wr_size = 0; req_kind = 0; req_space = 0; req_va = 0;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_vpn[i] = 0; m_ctx[i] = 0; m_ppn[i] = 0; m_glob[i] = 0;
      m_size[i] = 0; m_priv[i] = 0; m_wr[i] = 0; m_nfo[i] = 0; m_side[i] = 0;
    end
    m_used = '0; m_fsr = '0; m_far = '0; m_tag = '0;

    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12", "reset outcome", 64'({rsp_hit, rsp_miss, rsp_fault, rsp_prot}), 64'd0);
    chk("R12", "reset fsr", 64'(stat_fsr), 64'd0);
    chk("R12", "reset far/tag", stat_far | stat_tag, 64'd0);
    chk("R12", "reset used", 64'(used_bits), 64'd0);

    // R11 translation disabled, table loaded so a match would exist
    wr_ent(2, VA_A[63:13], pri_ctx, 28'h0FEDCBA, 1, 1, 2'd0, 1, 0, 1, 1);
    lookup(VA_A, 2'd0, 2'd0, 1, "R11");
    lookup(VA_A ^ 64'h0F00_0000_0000_0ABC, 2'd1, 2'd1, 1, "R11");
    lookup(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 2'd2, 0, "R11");
    wr_ent(2, 51'd0, 13'd0, 28'd0, 0, 0, 2'd0, 0, 0, 0, 0);
    mmu_en = 1;

    // R1 / R4 page size masking and address build
    for (int sz = 0; sz < 4; sz++) begin
      wr_ent(0, VA_A[63:13], pri_ctx, 28'hABCDE0F ^ 28'(sz * 28'h1111111), 1, 0,
             sz[1:0], 0, 1, 0, 0);
      lookup(VA_A, 2'd0, 2'd0, 0, "R1 R4");
      for (int b = 13; b < 25; b++) lookup(VA_A ^ (64'd1 << b), 2'd0, 2'd0, 0, "R1 R4");
      lookup(VA_A ^ (64'd1 << 63), 2'd0, 2'd0, 0, "R1");
    end

    // R2 / R3 context selection and global entries
    for (int g = 0; g < 2; g++) begin
      wr_ent(1, VA_B[63:13], sec_ctx, 28'h0123456, 1, g[0], 2'd0, 0, 1, 0, 0);
      for (int s = 0; s < 4; s++) lookup(VA_B | 64'h123, 2'd0, s[1:0], 0, "R2 R3");
    end
    wr_ent(1, VA_B[63:13], sec_ctx, 28'h0123456, 0, 1, 2'd0, 0, 1, 0, 0);
    lookup(VA_B, 2'd0, 2'd1, 0, "R2");

    // R5 lowest index wins
    wr_ent(6, VA_C[63:13], 13'd0, 28'h6666666, 1, 1, 2'd0, 0, 1, 0, 0);
    wr_ent(3, VA_C[63:13], 13'd0, 28'h3333333, 1, 1, 2'd0, 0, 0, 0, 0);
    lookup(VA_C, 2'd0, 2'd0, 0, "R5");
    wr_ent(5, VA_C[63:13], 13'd0, 28'h5555555, 1, 1, 2'd3, 0, 1, 0, 0);
    wr_ent(3, VA_C[63:13], 13'd0, 28'h3333333, 0, 1, 2'd0, 0, 0, 0, 0);
    lookup(VA_C | 64'h1_E000, 2'd1, 2'd0, 0, "R5");

    // R6 R7 R8 fault conditions and recording, with a clear halfway
    for (int a = 0; a < 16; a++) begin
      if (a == 8) clr_status();
      wr_ent(4, VA_D[63:13], 13'h0, 28'h0ABC123, 1, 1, 2'd1, a[0], a[1], a[2], a[3]);
      for (int k = 0; k < 3; k++)
        for (int u = 0; u < 2; u++)
          lookup(VA_D + 64'h1234, k[1:0], a[1] ? 2'd1 : 2'd2, u[0], "R6 R7 R8");
    end

    // R9 misses touch only the tag-access register
    lookup(64'h1111_0000_0000_0000, 2'd1, 2'd0, 1, "R9");
    lookup(64'h2222_0000_0000_4000, 2'd2, 2'd2, 0, "R9");

    // R12 response lasts one cycle
    @(negedge clk);
    chk("R12", "rsp_valid drops", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R12: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule